// File: doc/BRIEF.md
# Asynchronous Schedule Release Handshake

This block tells host software when memory that held queue heads, now unlinked from the circular asynchronous schedule, may be freed or reused. Software first unlinks the queue heads. It then rings a doorbell bit in a small control register. The block does not release the handshake after a fixed delay. It captures the set of queue-head addresses that the traversal engine holds at that moment: the current pointer and a parameterised number of cached pointers. The block then watches the stream of queue-head fetches until the traversal has moved beyond every captured address. At that point it sets a status flag, drops the doorbell, and can raise an interrupt.

The traversal engine reports each fetch on a one-cycle event port, together with the fetched address and the flag that marks the single head of the circular list. As a conservative fallback, two fetches of the list head after the snapshot clear it completely. If the schedule is disabled, nothing can be cached, so a doorbell completes at once.

Top module: `asch_doorbell_top`

## Requirements
- R1: After reset the register reads 0 in all three bits and `irq` is 0.
- R2: The register bits are: bit 0 doorbell, bit 1 status, bit 2 interrupt enable. Writing 1 to bit 0 sets the doorbell. Writing 0 to bit 0 never clears it. Every write loads bit 2 with the written value.
- R3: The status bit clears when 1 is written to bit 1. Writing 0 to bit 1 leaves it unchanged.
- R4: `irq` is 1 exactly when status and interrupt enable are both 1.
- R5: With `sched_en` low, a set doorbell completes at the next clock edge. After that edge, status reads 1 and the doorbell reads 0.
- R6: At the first edge with the doorbell set, `sched_en` high and no handshake pending, the block captures the valid cached addresses and the valid current address. If none is valid, it completes at that same edge.
- R7: While a handshake is pending, a fetch whose address equals a captured address marks that entry as passed. A fetch whose address matches no captured address retires every passed entry. The handshake completes at the edge that retires the last entry, and never at an edge with no fetch.
- R8: The second fetch with the head flag set, counted from the snapshot, retires all entries. That completes the handshake at that edge.
- R9: Completion sets status and clears the doorbell at the same edge. Status never rises without a set doorbell.
- R10: A doorbell write while a handshake is pending takes no new snapshot. Completion still follows the original snapshot.
- R11: If `sched_en` falls while a handshake is pending, it completes at the next edge.
- R12: If completion and a status clear-write fall on the same edge, status ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | 3 | Write data: bit 0 doorbell, bit 1 status clear, bit 2 interrupt enable |
| csr_rd_data | output | 3 | Register read value, same bit layout |
| sched_en | input | 1 | Asynchronous schedule enabled |
| qh_fetch_valid | input | 1 | One queue-head fetch reported this cycle |
| qh_fetch_addr | input | ADDR_W | Address of the fetched queue head |
| qh_fetch_head | input | 1 | The fetched queue head is the list head |
| cur_qh_valid | input | 1 | The traversal holds a current queue-head pointer |
| cur_qh_addr | input | ADDR_W | Current queue-head address |
| cache_qh_valid | input | CACHE_N | Valid flag per cached pointer |
| cache_qh_addr | input | CACHE_N*ADDR_W | Cached pointer addresses, entry i at bits i*ADDR_W upward |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted snapshot entry or passed flag shows at the ports as status rising at the wrong fetch: too early if an entry is lost, late or never if a stale entry lingers. The error becomes visible at the first fetch that should or should not retire the last entry. A wrong pending-state flag shows either as a second snapshot or as a completion with no fetch, within one edge of the doorbell or of a `sched_en` change. The register path shows errors on the read port the cycle after the write.

// File: rtl/asch_pkg.sv
package asch_pkg;
  localparam int CSR_W  = 3;
  localparam int BIT_DB = 0;
  localparam int BIT_ST = 1;
  localparam int BIT_IE = 2;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_WAIT = 1'b1
  } hs_state_e;
endpackage

// File: rtl/asch_snapshot.sv
module asch_snapshot #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      capture,
  input  logic [ENTRIES-1:0]        cap_valid,
  input  logic [ENTRIES*ADDR_W-1:0] cap_addr,
  input  logic                      ev_valid,
  input  logic [ADDR_W-1:0]         ev_addr,
  input  logic                      flush,
  output logic                      empty_nxt
);
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [ADDR_W-1:0]  addr_n [ENTRIES];
  logic [ENTRIES-1:0] held_q, held_n;
  logic [ENTRIES-1:0] live_q, live_n;
  logic [ENTRIES-1:0] seen_q, seen_n;
  logic [ENTRIES-1:0] match;
  logic               member;
  logic               upd_en;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_match
    assign match[gi] = held_q[gi] && (addr_q[gi] == ev_addr);
  end

  assign member = |match;
  assign upd_en = capture | ev_valid | flush;

  always_comb begin
    held_n = held_q;
    live_n = live_q;
    seen_n = seen_q;
    for (int i = 0; i < ENTRIES; i++) begin
      addr_n[i] = addr_q[i];
    end
    if (capture) begin
      held_n = cap_valid;
      live_n = cap_valid;
      seen_n = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        addr_n[i] = cap_addr[i*ADDR_W +: ADDR_W];
      end
    end else if (ev_valid) begin
      seen_n = seen_q | match;
      if (!member) begin
        live_n = live_q & ~seen_q;
      end
    end
    if (flush) begin
      live_n = '0;
    end
  end

  assign empty_nxt = ~|live_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      live_q <= '0;
      seen_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        addr_q[i] <= '0;
      end
    end else if (upd_en) begin
      held_q <= held_n;
      live_q <= live_n;
      seen_q <= seen_n;
      for (int i = 0; i < ENTRIES; i++) begin
        addr_q[i] <= addr_n[i];
      end
    end
  end
endmodule

// File: rtl/asch_head_sweep.sv
module asch_head_sweep #(
  parameter int HEAD_LAPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ev_valid,
  input  logic ev_head,
  output logic flush
);
  localparam int CW = $clog2(HEAD_LAPS + 1);
  localparam logic [CW-1:0] LAST = CW'(HEAD_LAPS - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          hit;
  logic          cnt_en;

  assign hit    = ev_valid && ev_head;
  assign flush  = hit && (cnt_q >= LAST);
  assign cnt_en = restart | hit;

  always_comb begin
    cnt_n = cnt_q;
    if (restart) begin
      cnt_n = '0;
    end else if (hit && (cnt_q != CW'(HEAD_LAPS))) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/asch_csr_ctrl.sv
module asch_csr_ctrl
  import asch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             sched_en,
  input  logic             ev_valid,
  input  logic             snap_empty_nxt,
  output logic             capture,
  output logic             ev_gated,
  output logic             done,
  output logic             waiting,
  output logic [CSR_W-1:0] csr
);
  hs_state_e state_q, state_n;
  logic      db_q, db_n;
  logic      st_q, st_n;
  logic      ie_q, ie_n;
  logic      reg_en;

  assign waiting  = (state_q == HS_WAIT);
  assign capture  = !waiting && db_q && sched_en;
  assign ev_gated = waiting && sched_en && ev_valid;
  assign done     = db_q && (!sched_en || snap_empty_nxt);
  assign reg_en   = wr_en | done;

  always_comb begin
    state_n = state_q;
    if (done) begin
      state_n = HS_IDLE;
    end else if (capture) begin
      state_n = HS_WAIT;
    end
  end

  always_comb begin
    db_n = db_q;
    st_n = st_q;
    ie_n = ie_q;
    if (wr_en) begin
      db_n = db_q | wr_data[BIT_DB];
      st_n = st_q & ~wr_data[BIT_ST];
      ie_n = wr_data[BIT_IE];
    end
    if (done) begin
      db_n = 1'b0;
      st_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q <= 1'b0;
      st_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (reg_en) begin
      db_q <= db_n;
      st_q <= st_n;
      ie_q <= ie_n;
    end
  end

  always_comb begin
    csr         = '0;
    csr[BIT_DB] = db_q;
    csr[BIT_ST] = st_q;
    csr[BIT_IE] = ie_q;
  end
endmodule

// File: rtl/asch_doorbell_top.sv
module asch_doorbell_top
  import asch_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CACHE_N   = 4,
  parameter int HEAD_LAPS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      csr_wr_en,
  input  logic [CSR_W-1:0]          csr_wr_data,
  output logic [CSR_W-1:0]          csr_rd_data,
  input  logic                      sched_en,
  input  logic                      qh_fetch_valid,
  input  logic [ADDR_W-1:0]         qh_fetch_addr,
  input  logic                      qh_fetch_head,
  input  logic                      cur_qh_valid,
  input  logic [ADDR_W-1:0]         cur_qh_addr,
  input  logic [CACHE_N-1:0]        cache_qh_valid,
  input  logic [CACHE_N*ADDR_W-1:0] cache_qh_addr,
  output logic                      irq
);
  localparam int ENTRIES = CACHE_N + 1;

  logic [ENTRIES-1:0]        cap_valid;
  logic [ENTRIES*ADDR_W-1:0] cap_addr;
  logic                      capture_w;
  logic                      ev_w;
  logic                      done_w;
  logic                      waiting_w;
  logic                      flush_w;
  logic                      empty_nxt_w;

  assign cap_valid = {cur_qh_valid, cache_qh_valid};
  assign cap_addr  = {cur_qh_addr, cache_qh_addr};

  asch_csr_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (csr_wr_en),
    .wr_data        (csr_wr_data),
    .sched_en       (sched_en),
    .ev_valid       (qh_fetch_valid),
    .snap_empty_nxt (empty_nxt_w),
    .capture        (capture_w),
    .ev_gated       (ev_w),
    .done           (done_w),
    .waiting        (waiting_w),
    .csr            (csr_rd_data)
  );

  asch_snapshot #(
    .ADDR_W  (ADDR_W),
    .ENTRIES (ENTRIES)
  ) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture_w),
    .cap_valid (cap_valid),
    .cap_addr  (cap_addr),
    .ev_valid  (ev_w),
    .ev_addr   (qh_fetch_addr),
    .flush     (flush_w),
    .empty_nxt (empty_nxt_w)
  );

  asch_head_sweep #(
    .HEAD_LAPS (HEAD_LAPS)
  ) u_sweep (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (capture_w),
    .ev_valid (ev_w),
    .ev_head  (qh_fetch_head),
    .flush    (flush_w)
  );

  assign irq = csr_rd_data[BIT_ST] & csr_rd_data[BIT_IE];
endmodule

// File: rtl/asch_doorbell_chk.sv
module asch_doorbell_chk
  import asch_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [CSR_W-1:0] wr_data,
  input logic [CSR_W-1:0] csr,
  input logic             sched_en,
  input logic             ev_valid,
  input logic             irq,
  input logic             done,
  input logic             waiting
);
  logic db, st;
  assign db = csr[BIT_DB];
  assign st = csr[BIT_ST];

  AST_DB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (db && !done) |=> db); // R2
  AST_ST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (st && !(wr_en && wr_data[BIT_ST])) |=> st); // R3
  AST_IRQ_NEEDS_ST: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st); // R4
  AST_OFF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (db && !waiting && !sched_en) |=> (st && !db)); // R5
  AST_WAIT_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && sched_en && !ev_valid) |=> waiting); // R7
  AST_DONE_CLEARS_DB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st) |-> $fell(db)); // R9
  AST_OFF_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !sched_en) |=> (!waiting && st && !db)); // R11
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !sched_en && wr_en && wr_data[BIT_ST]) |=> st); // R12
endmodule

bind asch_doorbell_top asch_doorbell_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (csr_wr_en),
  .wr_data  (csr_wr_data),
  .csr      (csr_rd_data),
  .sched_en (sched_en),
  .ev_valid (qh_fetch_valid),
  .irq      (irq),
  .done     (done_w),
  .waiting  (waiting_w)
);

// File: tb/asch_doorbell_top_tb.sv
module asch_doorbell_top_tb;
  localparam int AW = 32;
  localparam int CN = 4;
  localparam int NE = CN + 1;

  logic          clk;
  logic          rst_n;
  logic          csr_wr_en;
  logic [2:0]    csr_wr_data;
  logic [2:0]    csr_rd_data;
  logic          sched_en;
  logic          qh_fetch_valid;
  logic [AW-1:0] qh_fetch_addr;
  logic          qh_fetch_head;
  logic          cur_qh_valid;
  logic [AW-1:0] cur_qh_addr;
  logic [CN-1:0] cache_qh_valid;
  logic [CN*AW-1:0] cache_qh_addr;
  logic          irq;

  int    checks;
  int    failures;
  int    cycles;
  string phase;

  asch_doorbell_top #(.ADDR_W(AW), .CACHE_N(CN), .HEAD_LAPS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
    .csr_rd_data(csr_rd_data), .sched_en(sched_en), .qh_fetch_valid(qh_fetch_valid),
    .qh_fetch_addr(qh_fetch_addr), .qh_fetch_head(qh_fetch_head),
    .cur_qh_valid(cur_qh_valid), .cur_qh_addr(cur_qh_addr),
    .cache_qh_valid(cache_qh_valid), .cache_qh_addr(cache_qh_addr), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference
  bit          m_db, m_st, m_ie, m_wait, m_done, m_member, m_any;
  int          m_heads;
  logic [AW-1:0] s_addr [NE];
  bit          s_held [NE];
  bit          s_live [NE];
  bit          s_seen [NE];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_db = 0; m_st = 0; m_ie = 0; m_wait = 0; m_heads = 0;
    end else begin
      m_done = 0;
      if (m_db) begin
        if (!sched_en) begin
          m_done = 1;
        end else if (!m_wait) begin
          m_any = 0;
          for (int i = 0; i < NE; i++) begin
            if (i < CN) begin
              s_held[i] = cache_qh_valid[i];
              s_addr[i] = cache_qh_addr[i*AW +: AW];
            end else begin
              s_held[i] = cur_qh_valid;
              s_addr[i] = cur_qh_addr;
            end
            s_live[i] = s_held[i];
            s_seen[i] = 0;
            m_any |= s_live[i];
          end
          m_heads = 0;
          if (!m_any) m_done = 1; else m_wait = 1;
        end else if (qh_fetch_valid) begin
          m_member = 0;
          for (int i = 0; i < NE; i++)
            if (s_held[i] && s_addr[i] == qh_fetch_addr) m_member = 1;
          if (!m_member) begin
            for (int i = 0; i < NE; i++) if (s_seen[i]) s_live[i] = 0;
          end else begin
            for (int i = 0; i < NE; i++)
              if (s_held[i] && s_addr[i] == qh_fetch_addr) s_seen[i] = 1;
          end
          if (qh_fetch_head) m_heads++;
          m_any = 0;
          for (int i = 0; i < NE; i++) begin
            if (m_heads >= 2) s_live[i] = 0;
            m_any |= s_live[i];
          end
          if (!m_any) m_done = 1;
        end
      end
      if (csr_wr_en) begin
        m_db = m_db | csr_wr_data[0];
        m_st = m_st & ~csr_wr_data[1];
        m_ie = csr_wr_data[2];
      end
      if (m_done) begin
        m_db = 0; m_st = 1; m_wait = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (csr_rd_data !== {m_ie, m_st, m_db} || irq !== (m_st & m_ie)) begin
        failures++;
        $display("FAIL %s model: csr=%b irq=%b expected csr=%b irq=%b",
                 phase, csr_rd_data, irq, {m_ie, m_st, m_db}, m_st & m_ie);
      end
    end
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic expect_csr(input logic [2:0] exp, input string tag);
    checks++;
    if (csr_rd_data !== exp || irq !== (exp[1] & exp[2])) begin
      failures++;
      $display("FAIL %s: csr=%b irq=%b expected csr=%b irq=%b",
               tag, csr_rd_data, irq, exp, exp[1] & exp[2]);
    end
  endtask

  task automatic wr(input logic [2:0] d);
    csr_wr_en = 1; csr_wr_data = d;
    @(negedge clk);
    csr_wr_en = 0; csr_wr_data = '0;
  endtask

  task automatic fetch(input logic [AW-1:0] a, input logic h);
    qh_fetch_valid = 1; qh_fetch_addr = a; qh_fetch_head = h;
    @(negedge clk);
    qh_fetch_valid = 0; qh_fetch_head = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_abc();
    cache_qh_valid = 4'b0011;
    cache_qh_addr  = '0;
    cache_qh_addr[0*AW +: AW] = 32'h100;
    cache_qh_addr[1*AW +: AW] = 32'h140;
    cur_qh_valid = 1; cur_qh_addr = 32'h180;
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0; phase = "R1";
    rst_n = 0; csr_wr_en = 0; csr_wr_data = '0; sched_en = 0;
    qh_fetch_valid = 0; qh_fetch_addr = '0; qh_fetch_head = 0;
    cur_qh_valid = 0; cur_qh_addr = '0; cache_qh_valid = '0; cache_qh_addr = '0;
    idle(3);
    expect_csr(3'b000, "R1 reset");
    rst_n = 1;
    idle(2);
    expect_csr(3'b000, "R1 after release");

    phase = "R2";
    wr(3'b100);
    expect_csr(3'b100, "R2 enable write");
    phase = "R5";
    wr(3'b101);
    expect_csr(3'b101, "R5 doorbell set");
    idle(1);
    expect_csr(3'b110, "R5 disabled completes, R4 irq");

    phase = "R3";
    wr(3'b100);
    expect_csr(3'b110, "R3 write zero keeps status");
    wr(3'b110);
    expect_csr(3'b100, "R3 w1c clears");

    phase = "R9";
    sched_en = 1; load_abc();
    fetch(32'h100, 0); fetch(32'h300, 1); fetch(32'h300, 1);
    expect_csr(3'b100, "R9 no doorbell no status");

    phase = "R6";
    cache_qh_valid = '0; cur_qh_valid = 0;
    wr(3'b101);
    idle(1);
    expect_csr(3'b110, "R6 empty snapshot completes");
    wr(3'b110);

    phase = "R7";
    load_abc();
    wr(3'b101);
    idle(1);
    fetch(32'h180, 0);
    fetch(32'h1c0, 0);
    phase = "R2";
    wr(3'b100);
    expect_csr(3'b101, "R2 zero write keeps doorbell");
    phase = "R7";
    fetch(32'h100, 0);
    fetch(32'h140, 0);
    expect_csr(3'b101, "R7 passed but not retired");
    idle(3);
    expect_csr(3'b101, "R7 no fetch no completion");
    fetch(32'h1e0, 0);
    expect_csr(3'b110, "R7 last retire completes");
    wr(3'b110);

    phase = "R8";
    load_abc();
    wr(3'b101);
    idle(1);
    fetch(32'h200, 1);
    expect_csr(3'b101, "R8 one head pass");
    fetch(32'h200, 1);
    expect_csr(3'b110, "R8 second head pass");
    wr(3'b110);

    phase = "R10";
    load_abc();
    wr(3'b101);
    idle(1);
    cache_qh_valid = 4'b0111;
    cache_qh_addr[2*AW +: AW] = 32'h240;
    wr(3'b101);
    idle(1);
    fetch(32'h100, 0); fetch(32'h140, 0); fetch(32'h180, 0);
    expect_csr(3'b101, "R10 waiting");
    fetch(32'h280, 0);
    expect_csr(3'b110, "R10 original snapshot only");
    wr(3'b110);

    phase = "R11";
    load_abc();
    wr(3'b101);
    idle(1);
    fetch(32'h100, 0);
    sched_en = 0;
    idle(1);
    expect_csr(3'b110, "R11 disable during wait");
    sched_en = 1;

    phase = "R12";
    wr(3'b101);
    idle(1);
    expect_csr(3'b111, "R12 pending with status set");
    sched_en = 0;
    wr(3'b110);
    expect_csr(3'b110, "R12 set wins over clear");
    sched_en = 1;
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule